// File: doc/BRIEF.md
# Nibble-Wide Link Port

This block is one end of a point-to-point link that moves parallel words between two processors over four data wires, a link clock and an acknowledge wire. A configuration pin picks the role. As a transmitter, the block takes words from a valid/ready input stream and sends them as a sequence of 4-bit nibbles. As a receiver, it samples the incoming link clock, rebuilds each word and offers it on a valid/ready output stream. Both ends run on the same system clock. The sender produces the link clock as a slow toggle, and the receiver samples it as data.

Two more pins set the rate and the word length. In single rate, one nibble crosses per full link-clock period, on the rising edge. In double rate, a nibble crosses on every edge. Words are either 32 or 48 bits long. Each direction keeps two word buffers. The transmitter holds one word while it shifts the previous one out. The receiver assembles a word while the previous one waits for the consumer.

Back-pressure rules:
- Input stream: a word is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` depends only on internal state.
- Output stream: a word is handed over on a cycle where `m_valid` and `m_ready` are both high. While `m_ready` is low, `m_valid` and `m_data` do not change.
- Across the link: the receiver drops acknowledge when both of its buffers are full. The transmitter does not start a word until it has seen acknowledge high.

Top module: `nibble_link`

## Requirements
- R1: After reset `m_valid` and `lnk_clk_o` are 0. A port set as receiver drives `lnk_ack_o` high. A port set as transmitter drives `s_ready` high.
- R2: `cfg_tx`=1 selects the transmit role and `cfg_tx`=0 the receive role. In the transmit role `m_valid` and `lnk_ack_o` stay 0. In the receive role `s_ready` and `lnk_clk_o` stay 0.
- R3: Nibbles go least significant first, with bits [3:0] first. With `cfg_wide`=0 a word is 8 nibbles: `s_data[47:32]` is never sent and `m_data[47:32]` reads 0. With `cfg_wide`=1 a word is 12 nibbles.
- R4: With `cfg_dbl`=0 the nibble appears on `lnk_dat_o` together with each rising edge, and the falling edge carries nothing. With `cfg_dbl`=1 a new nibble appears with every edge.
- R5: Within a word, each link-clock level lasts exactly HALF_CYC system cycles (default 3). The link clock is low whenever no word is in flight, including after the last edge of a word.
- R6: The transmitter raises `s_ready` again while a word is still shifting out, so a second word is accepted during the transfer of the first.
- R7: The transmitter starts a word only after it has sampled `lnk_ack_i` high. While acknowledge is low, the link clock stays quiet.
- R8: The receiver drives `lnk_ack_o` low exactly while a complete assembled word and a pending output word are both held. Under any back-pressure, words arrive complete and in order.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx | input | 1 | 1 = transmit role, 0 = receive role |
| cfg_dbl | input | 1 | 1 = nibble on every link edge, 0 = on rising edges only |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input holding slot is free |
| s_data | input | 48 | Input word |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer accepts the output word |
| m_data | output | 48 | Output word |
| lnk_clk_o | output | 1 | Link clock driven when transmitting |
| lnk_dat_o | output | 4 | Link nibble driven when transmitting |
| lnk_ack_i | input | 1 | Acknowledge from the far receiver |
| lnk_clk_i | input | 1 | Link clock from the far transmitter |
| lnk_dat_i | input | 4 | Link nibble from the far transmitter |
| lnk_ack_o | output | 1 | Acknowledge to the far transmitter |

## Verification
At the receiver, the cycle that moves a finished word into the output slot can be the same cycle in which the consumer takes the previous word. The same collision occurs at the transmitter: a new input word can be accepted while the link clock is toggling. The bench connects a transmitting port to a receiving one and drives `m_ready` with a periodic stall pattern. This makes output drains land on the cycle a word completes. It also holds `m_ready` low for a long stretch, so both receive buffers fill and acknowledge falls. It then judges every delivered word against an arithmetic sequence. A separate link monitor decodes the wire nibbles and edge spacing on its own.

// File: rtl/nibble_link_pkg.sv
package nibble_link_pkg;
  localparam int NIB_W = 4;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_RUN  = 1'b1
  } tx_st_e;
endpackage

// File: rtl/nibble_link_tx.sv
module nibble_link_tx #(
  parameter int WORD_W   = 48,
  parameter int NARROW_W = 32,
  parameter int HALF_CYC = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic                              dbl,
  input  logic                              wide,
  input  logic                              s_valid,
  output logic                              s_ready,
  input  logic [WORD_W-1:0]                 s_data,
  output logic                              lk_clk,
  output logic [nibble_link_pkg::NIB_W-1:0] lk_dat,
  input  logic                              lk_ack
);
  import nibble_link_pkg::*;

  localparam int NIB = NIB_W;
  localparam int HP  = (HALF_CYC < 3) ? 3 : HALF_CYC;
  localparam int NWD = WORD_W / NIB;
  localparam int NNR = NARROW_W / NIB;
  localparam int EW  = $clog2(2 * NWD + 1);
  localparam int PW  = $clog2(HP + 1);

  tx_st_e            st;
  logic [WORD_W-1:0] buf_d, sh;
  logic              buf_v, clk_q, ack_r;
  logic [NIB-1:0]    dat_q;
  logic [EW-1:0]     edg, edg_total;
  logic [PW-1:0]     ph;

  assign edg_total = dbl ? (wide ? EW'(NWD) : EW'(NNR))
                         : (wide ? EW'(2 * NWD) : EW'(2 * NNR));
  assign s_ready = en && !buf_v;
  assign lk_clk  = clk_q;
  assign lk_dat  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      buf_d <= '0;
      buf_v <= 1'b0;
      sh    <= '0;
      clk_q <= 1'b0;
      dat_q <= '0;
      ack_r <= 1'b0;
      edg   <= '0;
      ph    <= '0;
    end else begin
      ack_r <= lk_ack;
      if (s_valid && s_ready) begin
        buf_d <= s_data;
        buf_v <= 1'b1;
      end
      case (st)
        TX_IDLE: begin
          if (en && buf_v && ack_r) begin
            st    <= TX_RUN;
            buf_v <= 1'b0;
            dat_q <= buf_d[NIB-1:0];
            sh    <= buf_d >> NIB;
            clk_q <= 1'b1;
            edg   <= EW'(1);
            ph    <= '0;
          end
        end
        TX_RUN: begin
          if (ph == PW'(HP - 1)) begin
            ph <= '0;
            if (edg == edg_total) begin
              st <= TX_IDLE;
            end else begin
              clk_q <= ~clk_q;
              edg   <= edg + EW'(1);
              if (dbl || !clk_q) begin
                dat_q <= sh[NIB-1:0];
                sh    <= sh >> NIB;
              end
            end
          end else begin
            ph <= ph + PW'(1);
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R7
  property p_start_needs_ack;
    @(posedge clk) disable iff (!rst_n) $rose(st == TX_RUN) |-> $past(ack_r);
  endproperty
  start_after_ack_chk: assert property (p_start_needs_ack);

  // R5
  property p_level_min;
    @(posedge clk) disable iff (!rst_n) !$stable(clk_q) |=> $stable(clk_q);
  endproperty
  link_level_hold_chk: assert property (p_level_min);

  // R5
  property p_idle_low;
    @(posedge clk) disable iff (!rst_n) (st == TX_IDLE) |-> !lk_clk;
  endproperty
  idle_clock_low_chk: assert property (p_idle_low);

  // R6
  property p_single_slot;
    @(posedge clk) disable iff (!rst_n) (s_valid && s_ready) |=> !s_ready;
  endproperty
  slot_fill_chk: assert property (p_single_slot);
endmodule

// File: rtl/nibble_link_rx.sv
module nibble_link_rx #(
  parameter int WORD_W   = 48,
  parameter int NARROW_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic                              dbl,
  input  logic                              wide,
  input  logic                              lk_clk,
  input  logic [nibble_link_pkg::NIB_W-1:0] lk_dat,
  output logic                              lk_ack,
  output logic                              m_valid,
  input  logic                              m_ready,
  output logic [WORD_W-1:0]                 m_data
);
  import nibble_link_pkg::*;

  localparam int NIB = NIB_W;
  localparam int NWD = WORD_W / NIB;
  localparam int NNR = NARROW_W / NIB;
  localparam int CW  = $clog2(NWD);

  logic              clk_r, clk_rr;
  logic [NIB-1:0]    dat_r;
  logic [WORD_W-1:0] sh, hold;
  logic              asm_full, hold_v, cap, move;
  logic [CW-1:0]     cnt, last;

  assign last    = wide ? CW'(NWD - 1) : CW'(NNR - 1);
  assign cap     = en && (clk_r ^ clk_rr) && (dbl || clk_r) && !asm_full;
  assign move    = asm_full && (!hold_v || m_ready);
  assign lk_ack  = en && !(asm_full && hold_v);
  assign m_valid = en && hold_v;
  assign m_data  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_r    <= 1'b0;
      clk_rr   <= 1'b0;
      dat_r    <= '0;
      sh       <= '0;
      hold     <= '0;
      asm_full <= 1'b0;
      hold_v   <= 1'b0;
      cnt      <= '0;
    end else begin
      clk_r  <= lk_clk;
      clk_rr <= clk_r;
      dat_r  <= lk_dat;
      if (cap) begin
        if (cnt == '0) sh <= WORD_W'(dat_r);
        else           sh[NIB*cnt +: NIB] <= dat_r;
        if (cnt == last) begin
          cnt      <= '0;
          asm_full <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (move) begin
        hold     <= sh;
        hold_v   <= 1'b1;
        asm_full <= 1'b0;
      end else if (hold_v && m_ready) begin
        hold_v <= 1'b0;
      end
    end
  end

  // R9
  property p_out_hold;
    @(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data));
  endproperty
  out_stable_chk: assert property (p_out_hold);

  // R8
  property p_asm_keep;
    @(posedge clk) disable iff (!rst_n)
      (asm_full && hold_v && !m_ready) |=> (asm_full && $stable(sh));
  endproperty
  asm_keep_chk: assert property (p_asm_keep);

  // R8
  property p_ack_low_when_full;
    @(posedge clk) disable iff (!rst_n)
      (asm_full && hold_v && !m_ready) |=> !lk_ack;
  endproperty
  ack_full_chk: assert property (p_ack_low_when_full);
endmodule

// File: rtl/nibble_link.sv
module nibble_link #(
  parameter int WORD_W   = 48,
  parameter int NARROW_W = 32,
  parameter int HALF_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx,
  input  logic              cfg_dbl,
  input  logic              cfg_wide,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              lnk_clk_o,
  output logic [3:0]        lnk_dat_o,
  input  logic              lnk_ack_i,
  input  logic              lnk_clk_i,
  input  logic [3:0]        lnk_dat_i,
  output logic              lnk_ack_o
);
  nibble_link_tx #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W), .HALF_CYC(HALF_CYC)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_tx), .dbl(cfg_dbl), .wide(cfg_wide),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .lk_clk(lnk_clk_o), .lk_dat(lnk_dat_o), .lk_ack(lnk_ack_i)
  );

  nibble_link_rx #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!cfg_tx), .dbl(cfg_dbl), .wide(cfg_wide),
    .lk_clk(lnk_clk_i), .lk_dat(lnk_dat_i), .lk_ack(lnk_ack_o),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // R2
  property p_role_quiet;
    @(posedge clk) disable iff (!rst_n)
      cfg_tx |-> (!m_valid && !lnk_ack_o);
  endproperty
  role_quiet_chk: assert property (p_role_quiet);
endmodule

// File: tb/nibble_link_tb.sv
module nibble_link_tb;
  localparam int W = 48;
  localparam int HC = 3;
  localparam int NWORDS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic dbl = 1'b0, wide = 1'b0;
  logic s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic s_ready, s_ready_rx, m_valid_tx, ack_tx, lclk_rx;
  logic [W-1:0] m_data_tx, m_data;
  logic m_valid;
  logic m_ready = 1'b0;
  logic lclk, lack;
  logic [3:0] ldat, ldat_rx;

  int total = 0, bad = 0;
  int cfg = 0;
  bit run = 0;
  int rcv = 0, cyc = 0, hold_off = 0, snap = 0;
  bit stalled_prev = 0;
  logic [W-1:0] prev_data = '0;
  int medges = 0, mnib = 0, mword = 0, gap = 0, edge_all = 0;
  logic [W-1:0] masm = '0;
  logic lc_prev = 1'b0;
  bit seen_overlap = 0;

  nibble_link u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx(1'b1), .cfg_dbl(dbl), .cfg_wide(wide),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid_tx), .m_ready(1'b0), .m_data(m_data_tx),
    .lnk_clk_o(lclk), .lnk_dat_o(ldat), .lnk_ack_i(lack),
    .lnk_clk_i(1'b0), .lnk_dat_i(4'h0), .lnk_ack_o(ack_tx)
  );

  nibble_link u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_tx(1'b0), .cfg_dbl(dbl), .cfg_wide(wide),
    .s_valid(1'b0), .s_ready(s_ready_rx), .s_data('0),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .lnk_clk_o(lclk_rx), .lnk_dat_o(ldat_rx), .lnk_ack_i(1'b0),
    .lnk_clk_i(lclk), .lnk_dat_i(ldat), .lnk_ack_o(lack)
  );

  function automatic logic [W-1:0] word_of(int i, int c);
    logic [15:0] hi = 16'(i * 40503 + c * 7 + 16'h5A5A);
    logic [31:0] lo = 32'(i) * 32'h9E3779B9 + 32'h13579BDF + 32'(c);
    return {hi, lo};
  endfunction

  function automatic logic [W-1:0] exp_of(int i);
    logic [W-1:0] w = word_of(i, cfg);
    return wide ? w : {16'h0, w[31:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cfg=%0d act=%0h exp=%0h", req, cfg, act, expv);
    end
  endtask

  // link-side monitor: decodes nibbles and edge spacing from the wires
  always @(negedge clk) begin
    if (run) begin
      if (lclk != lc_prev) begin
        if (medges > 0) chk(gap == HC, "R5 level length", 64'(gap), 64'(HC));
        medges++;
        edge_all++;
        if (dbl || lclk) begin
          masm[mnib*4 +: 4] = ldat;
          mnib++;
        end
        if (medges == (dbl ? (wide ? 12 : 8) : (wide ? 24 : 16))) begin
          chk(masm == exp_of(mword), "R3 R4 wire word", 64'(masm), 64'(exp_of(mword)));
          chk(lclk == 1'b0, "R5 clock low after word", 64'(lclk), 64'(0));
          mword++;
          medges = 0;
          mnib = 0;
          masm = '0;
        end
        gap = 1;
      end else begin
        gap++;
      end
      lc_prev = lclk;
    end
  end

  // consumer with periodic and long stalls
  always @(negedge clk) begin
    if (run) begin
      bit r;
      cyc++;
      if (m_valid && stalled_prev)
        chk(m_data == prev_data, "R9 held data", 64'(m_data), 64'(prev_data));
      if (hold_off == 200) snap = edge_all;
      if (hold_off == 1) begin
        chk(lack == 1'b0, "R8 ack low when full", 64'(lack), 64'(0));
        chk(edge_all == snap, "R7 link quiet without ack", 64'(edge_all), 64'(snap));
        chk(s_ready == 1'b0, "R6 slot full under stall", 64'(s_ready), 64'(0));
        chk(m_valid == 1'b1, "R9 valid kept", 64'(m_valid), 64'(1));
      end
      r = (hold_off == 0) && ((cyc % 5) != 2);
      if (hold_off > 0) hold_off--;
      m_ready = r;
      if (m_valid && r) begin
        chk(m_data == exp_of(rcv), "R3 R8 delivered word", 64'(m_data), 64'(exp_of(rcv)));
        rcv++;
        if (rcv == 4) hold_off = 400;
      end
      stalled_prev = m_valid && !r;
      prev_data = m_data;
    end else begin
      m_ready = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 act=%0d exp=%0d", rcv, NWORDS);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      cfg = c;
      run = 0;
      @(negedge clk);
      dbl = c[0];
      wide = c[1];
      rst_n = 1'b0;
      s_valid = 1'b0;
      rcv = 0; cyc = 0; hold_off = 0; snap = 0; stalled_prev = 0;
      medges = 0; mnib = 0; mword = 0; gap = 0; edge_all = 0; masm = '0;
      lc_prev = 1'b0; seen_overlap = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(s_ready == 1'b1, "R1 tx ready", 64'(s_ready), 64'(1));
      chk(m_valid == 1'b0, "R1 rx valid", 64'(m_valid), 64'(0));
      chk(lclk == 1'b0, "R1 link clock", 64'(lclk), 64'(0));
      chk(lack == 1'b1, "R1 rx ack", 64'(lack), 64'(1));
      // R2
      chk(m_valid_tx == 1'b0 && ack_tx == 1'b0, "R2 tx role quiet",
          64'({m_valid_tx, ack_tx}), 64'(0));
      chk(s_ready_rx == 1'b0 && lclk_rx == 1'b0, "R2 rx role quiet",
          64'({s_ready_rx, lclk_rx}), 64'(0));
      run = 1;
      for (int i = 0; i < NWORDS; i++) begin
        bit ok;
        s_data = word_of(i, cfg);
        s_valid = 1'b1;
        forever begin
          ok = s_ready;
          @(negedge clk);
          if (ok) break;
        end
        if (medges > 0) seen_overlap = 1;
      end
      s_valid = 1'b0;
      while (rcv < NWORDS || mword < NWORDS) @(negedge clk);
      chk(seen_overlap, "R6 accept during transfer", 64'(seen_overlap), 64'(1));
      chk(mword == NWORDS, "R8 count on wire", 64'(mword), 64'(NWORDS));
      repeat (10) @(negedge clk);
      chk(lclk == 1'b0, "R5 idle clock low", 64'(lclk), 64'(0));
      chk(m_valid == 1'b0, "R8 nothing extra", 64'(m_valid), 64'(0));
    end
    run = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule